// File: doc/BRIEF.md
# Two-Stage Video Gain Controller

This block sets the amplifier gain for one video channel. Once per video line, upstream logic supplies four amplitude measurements: sync height, burst amplitude, composite peak and luma peak. It also supplies an ADC-clipping flag and a one-cycle line strobe. The host sets a target for each measurement. The gain is split into two parts. A front-end loop adjusts a 4-bit coarse code, where 0 is minimum gain and 15 is maximum gain. A back-end loop trims a 12-bit fine word, which is applied independently of the coarse code. Each loop has its own 4-bit mask that chooses which references it listens to. A typical setup lets the front end include the composite peak and keeps the back end on sync and luma. The back end then restores gain that a composite-peak limit took away from the front end.

Each loop works from the signed error target minus measurement, taken over its enabled references. It follows the smallest of these errors, which is the most restrictive one. A negative error lowers the gain on the same strobe. A positive error raises it only after a programmed number of quiet lines. Clipping forces the coarse code down straight away and stops the fine word from rising. In manual mode the host values drive the outputs and the loop state is frozen. A readback word always shows the gain that is being applied.

Top module: `agc_ctrl`

## Requirements
- R1: After reset, the coarse code is 8, the fine word is 0x800 and the readback is 0x8800.
- R2: With auto_en low, gain_coarse and gain_fine equal man_coarse and man_fine, and the readback equals {man_coarse, man_fine}.
- R3: With auto_en low, line strobes have no effect on the loop. When auto_en returns high, the outputs resume from the values held before manual mode began.
- R4: A strobe with adc_sat high lowers the coarse code by one, whatever the masks and errors are. The same strobe leaves the fine word unchanged and restarts the back-end delay count.
- R5: Each reference error is target minus measurement. The mask bit positions are 0 for sync, 1 for burst, 2 for composite peak and 3 for luma peak. Each loop follows the smallest error among its enabled references.
- R6: When the smallest error is negative, the coarse code drops by 1 (front end) and the fine word drops by inc_step (back end), both on that strobe.
- R7: When the smallest error is positive, the gain rises (coarse by 1, fine by inc_step) only if at least inc_delay non-overload strobes came before it since the last change of that stage. A strobe with zero error counts as non-overload.
- R8: Each loop uses only its own mask. When a loop's mask is all zero, that loop holds its gain.
- R9: The gains change only on an auto-mode line strobe. Measurement or clipping changes without a strobe have no effect.
- R10: The coarse code saturates at 0 and 15, and the fine word saturates at 0 and 4095.
- R11: In auto mode, gain_rb equals {gain_coarse, gain_fine}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| auto_en | input | 1 | 1 = automatic control, 0 = manual |
| line_stb | input | 1 | One-cycle pulse per line, measurements valid |
| adc_sat | input | 1 | ADC clipped on this line |
| meas_sync | input | 10 | Measured sync height |
| meas_burst | input | 10 | Measured burst amplitude |
| meas_cpeak | input | 10 | Measured composite peak |
| meas_lpeak | input | 10 | Measured luma peak |
| tgt_sync | input | 10 | Target sync height |
| tgt_burst | input | 10 | Target burst amplitude |
| tgt_cpeak | input | 10 | Target composite peak |
| tgt_lpeak | input | 10 | Target luma peak |
| fe_refs | input | 4 | Front-end reference mask |
| be_refs | input | 4 | Back-end reference mask |
| inc_step | input | 12 | Fine-gain step per update |
| inc_delay | input | 8 | Quiet lines required before an increase |
| man_coarse | input | 4 | Manual coarse code |
| man_fine | input | 12 | Manual fine word |
| gain_coarse | output | 4 | Applied coarse code |
| gain_fine | output | 12 | Applied fine word |
| gain_rb | output | 16 | Readback of applied gain |

## Verification
Every loop result is due one register stage after a strobe. The bench raises line_stb at a falling edge, so the design captures it at the next rising edge. The bench then lowers the strobe and samples the outputs at the following falling edge. Manual values and the readback follow the inputs without a clock, so they are checked in the same half-cycle that drives them. The delay test samples after every strobe to show the exact line on which the increase appears.

// File: rtl/agc_pkg.sv
package agc_pkg;
    localparam int MEAS_W = 10;
    localparam int ERR_W  = MEAS_W + 1;
    localparam int NREF   = 4;

    // mask bit positions
    localparam int REF_SYNC  = 0;
    localparam int REF_BURST = 1;
    localparam int REF_CPEAK = 2;
    localparam int REF_LPEAK = 3;

    typedef struct packed {
        logic                    valid;
        logic signed [ERR_W-1:0] err;
    } verdict_t;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_DOWN  = 2'd1,
        ACT_UP    = 2'd2,
        ACT_COUNT = 2'd3
    } act_e;

    function automatic logic signed [ERR_W-1:0] ref_err(
        input logic [MEAS_W-1:0] tgt,
        input logic [MEAS_W-1:0] meas
    );
        return signed'({1'b0, tgt}) - signed'({1'b0, meas});
    endfunction
endpackage

// File: rtl/agc_min_err.sv
module agc_min_err
    import agc_pkg::*;
(
    input  logic [NREF-1:0][MEAS_W-1:0] meas,
    input  logic [NREF-1:0][MEAS_W-1:0] tgt,
    input  logic [NREF-1:0]             mask,
    output verdict_t                    verdict
);
    logic signed [ERR_W-1:0] errs [NREF];

    for (genvar i = 0; i < NREF; i++) begin : g_err
        assign errs[i] = ref_err(tgt[i], meas[i]);
    end

    always_comb begin
        verdict.valid = 1'b0;
        verdict.err   = '0;
        for (int i = 0; i < NREF; i++) begin
            if (mask[i] && (!verdict.valid || errs[i] < verdict.err)) begin
                verdict.valid = 1'b1;
                verdict.err   = errs[i];
            end
        end
    end
endmodule

// File: rtl/agc_stage.sv
module agc_stage
    import agc_pkg::*;
#(
    parameter int          GW         = 4,
    parameter int          DW         = 8,
    parameter logic [GW-1:0] RST_VAL  = '0,
    parameter bit          CUT_ON_OVL = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          ovl,
    input  verdict_t      verdict,
    input  logic [GW-1:0] step,
    input  logic [DW-1:0] delay,
    output logic [GW-1:0] gain
);
    localparam logic [GW-1:0] GMAX = '1;
    localparam logic [DW-1:0] CMAX = '1;

    logic [DW-1:0] clean;
    logic [GW:0]   up_sum;
    logic [GW-1:0] up_val, dn_val;
    act_e          ovl_act, act;

    if (CUT_ON_OVL) begin : g_cut
        assign ovl_act = ACT_DOWN;
    end else begin : g_hold
        assign ovl_act = ACT_HOLD;
    end

    always_comb begin
        up_sum = {1'b0, gain} + {1'b0, step};
        up_val = up_sum[GW] ? GMAX : up_sum[GW-1:0];
        dn_val = (gain < step) ? '0 : gain - step;
        if (ovl)
            act = ovl_act;
        else if (!verdict.valid)
            act = ACT_HOLD;
        else if (verdict.err[ERR_W-1])
            act = ACT_DOWN;
        else if (verdict.err != '0 && clean >= delay)
            act = ACT_UP;
        else
            act = ACT_COUNT;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gain  <= RST_VAL;
            clean <= '0;
        end else if (tick) begin
            unique case (act)
                ACT_DOWN: begin
                    gain  <= dn_val;
                    clean <= '0;
                end
                ACT_UP: begin
                    gain  <= up_val;
                    clean <= '0;
                end
                ACT_COUNT: clean <= (clean == CMAX) ? clean : clean + 1'b1;
                default:   if (ovl) clean <= '0;
            endcase
        end
    end
endmodule

// File: rtl/agc_ctrl.sv
module agc_ctrl
    import agc_pkg::*;
#(
    parameter int               COARSE_W   = 4,
    parameter int               FINE_W     = 12,
    parameter int               DLY_W      = 8,
    parameter logic [COARSE_W-1:0] COARSE_RST = 4'h8,
    parameter logic [FINE_W-1:0]   FINE_RST   = 12'h800
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       auto_en,
    input  logic                       line_stb,
    input  logic                       adc_sat,
    input  logic [MEAS_W-1:0]          meas_sync,
    input  logic [MEAS_W-1:0]          meas_burst,
    input  logic [MEAS_W-1:0]          meas_cpeak,
    input  logic [MEAS_W-1:0]          meas_lpeak,
    input  logic [MEAS_W-1:0]          tgt_sync,
    input  logic [MEAS_W-1:0]          tgt_burst,
    input  logic [MEAS_W-1:0]          tgt_cpeak,
    input  logic [MEAS_W-1:0]          tgt_lpeak,
    input  logic [NREF-1:0]            fe_refs,
    input  logic [NREF-1:0]            be_refs,
    input  logic [FINE_W-1:0]          inc_step,
    input  logic [DLY_W-1:0]           inc_delay,
    input  logic [COARSE_W-1:0]        man_coarse,
    input  logic [FINE_W-1:0]          man_fine,
    output logic [COARSE_W-1:0]        gain_coarse,
    output logic [FINE_W-1:0]          gain_fine,
    output logic [COARSE_W+FINE_W-1:0] gain_rb
);
    localparam logic [COARSE_W-1:0] COARSE_STEP = 1;

    logic [NREF-1:0][MEAS_W-1:0] meas_v, tgt_v;
    verdict_t                    fe_verdict, be_verdict;
    logic [COARSE_W-1:0]         coarse_q;
    logic [FINE_W-1:0]           fine_q;
    logic                        tick;

    always_comb begin
        meas_v[REF_SYNC]  = meas_sync;
        meas_v[REF_BURST] = meas_burst;
        meas_v[REF_CPEAK] = meas_cpeak;
        meas_v[REF_LPEAK] = meas_lpeak;
        tgt_v[REF_SYNC]   = tgt_sync;
        tgt_v[REF_BURST]  = tgt_burst;
        tgt_v[REF_CPEAK]  = tgt_cpeak;
        tgt_v[REF_LPEAK]  = tgt_lpeak;
    end

    assign tick = line_stb && auto_en;

    agc_min_err u_fe_sel (.meas(meas_v), .tgt(tgt_v), .mask(fe_refs), .verdict(fe_verdict));
    agc_min_err u_be_sel (.meas(meas_v), .tgt(tgt_v), .mask(be_refs), .verdict(be_verdict));

    agc_stage #(.GW(COARSE_W), .DW(DLY_W), .RST_VAL(COARSE_RST), .CUT_ON_OVL(1'b1)) u_front (
        .clk(clk), .rst(rst), .tick(tick), .ovl(adc_sat), .verdict(fe_verdict),
        .step(COARSE_STEP), .delay(inc_delay), .gain(coarse_q)
    );

    agc_stage #(.GW(FINE_W), .DW(DLY_W), .RST_VAL(FINE_RST), .CUT_ON_OVL(1'b0)) u_back (
        .clk(clk), .rst(rst), .tick(tick), .ovl(adc_sat), .verdict(be_verdict),
        .step(inc_step), .delay(inc_delay), .gain(fine_q)
    );

    assign gain_coarse = auto_en ? coarse_q : man_coarse;
    assign gain_fine   = auto_en ? fine_q   : man_fine;
    assign gain_rb     = {gain_coarse, gain_fine};
endmodule

// File: rtl/agc_ctrl_chk.sv
module agc_ctrl_chk #(
    parameter int COARSE_W = 4,
    parameter int FINE_W   = 12
) (
    input logic                clk,
    input logic                rst,
    input logic                auto_en,
    input logic                line_stb,
    input logic                adc_sat,
    input logic [COARSE_W-1:0] gain_coarse,
    input logic [FINE_W-1:0]   gain_fine
);
    // R9
    coarse_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (auto_en && !line_stb) |=> (!auto_en || $stable(gain_coarse)));

    // R9
    fine_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (auto_en && !line_stb) |=> (!auto_en || $stable(gain_fine)));

    // R4
    sat_cut_chk: assert property (@(posedge clk) disable iff (rst)
        (auto_en && line_stb && adc_sat && gain_coarse != '0)
        |=> (!auto_en || gain_coarse == $past(gain_coarse) - 1'b1));

    // R4
    sat_fine_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (auto_en && line_stb && adc_sat) |=> (!auto_en || $stable(gain_fine)));

    // R6
    coarse_step_chk: assert property (@(posedge clk) disable iff (rst)
        (auto_en && line_stb)
        |=> (!auto_en || {1'b0, gain_coarse} <= {1'b0, $past(gain_coarse)} + 1'b1));
endmodule

bind agc_ctrl agc_ctrl_chk #(.COARSE_W(COARSE_W), .FINE_W(FINE_W)) u_chk (
    .clk(clk), .rst(rst), .auto_en(auto_en), .line_stb(line_stb), .adc_sat(adc_sat),
    .gain_coarse(gain_coarse), .gain_fine(gain_fine)
);

// File: tb/agc_ctrl_test.sv
module agc_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;

    // {fe_refs, be_refs, sync, burst, cpeak, lpeak, sat, exp_coarse, exp_fine}
    typedef struct packed {
        logic [3:0]  fe;
        logic [3:0]  be;
        logic [9:0]  s, b, c, l;
        logic        sat;
        logic [3:0]  ec;
        logic [11:0] ef;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{4'b0001, 4'b0000, 10'd600, 10'd500, 10'd500, 10'd500, 1'b0, 4'd7, 12'd2048},
        '{4'b0001, 4'b0001, 10'd600, 10'd500, 10'd500, 10'd500, 1'b0, 4'd6, 12'd2032},
        '{4'b0000, 4'b0000, 10'd500, 10'd500, 10'd500, 10'd500, 1'b1, 4'd5, 12'd2032},
        '{4'b0100, 4'b0001, 10'd400, 10'd500, 10'd600, 10'd500, 1'b0, 4'd4, 12'd2048},
        '{4'b1111, 4'b1111, 10'd500, 10'd500, 10'd500, 10'd510, 1'b0, 4'd3, 12'd2032},
        '{4'b0011, 4'b0011, 10'd450, 10'd480, 10'd500, 10'd500, 1'b0, 4'd4, 12'd2048},
        '{4'b0000, 4'b0000, 10'd300, 10'd300, 10'd300, 10'd300, 1'b0, 4'd4, 12'd2048},
        '{4'b1000, 4'b1000, 10'd500, 10'd500, 10'd500, 10'd400, 1'b0, 4'd5, 12'd2064}
    };

    logic clk = 0, rst = 1, auto_en = 1, line_stb = 0, adc_sat = 0;
    logic [9:0]  meas_sync = 500, meas_burst = 500, meas_cpeak = 500, meas_lpeak = 500;
    logic [9:0]  tgt_sync = 500, tgt_burst = 500, tgt_cpeak = 500, tgt_lpeak = 500;
    logic [3:0]  fe_refs = 0, be_refs = 0, man_coarse = 0;
    logic [11:0] inc_step = 16, man_fine = 0;
    logic [7:0]  inc_delay = 0;
    logic [3:0]  gain_coarse;
    logic [11:0] gain_fine;
    logic [15:0] gain_rb;
    int checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    agc_ctrl uut (
        .clk(clk), .rst(rst), .auto_en(auto_en), .line_stb(line_stb), .adc_sat(adc_sat),
        .meas_sync(meas_sync), .meas_burst(meas_burst), .meas_cpeak(meas_cpeak), .meas_lpeak(meas_lpeak),
        .tgt_sync(tgt_sync), .tgt_burst(tgt_burst), .tgt_cpeak(tgt_cpeak), .tgt_lpeak(tgt_lpeak),
        .fe_refs(fe_refs), .be_refs(be_refs), .inc_step(inc_step), .inc_delay(inc_delay),
        .man_coarse(man_coarse), .man_fine(man_fine),
        .gain_coarse(gain_coarse), .gain_fine(gain_fine), .gain_rb(gain_rb)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic strobe();
        line_stb = 1;
        @(negedge clk);
        line_stb = 0;
    endtask

    task automatic set_meas(input logic [9:0] s, b, c, l);
        meas_sync = s; meas_burst = b; meas_cpeak = c; meas_lpeak = l;
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check("R1 coarse", 16'(gain_coarse), 16'h8);
        check("R1 fine", 16'(gain_fine), 16'h800);
        check("R1 rb", gain_rb, 16'h8800);

        // R5 R6 R7 R8 table walk, delay 0, step 16
        for (int i = 0; i < NVEC; i++) begin
            fe_refs = VECS[i].fe; be_refs = VECS[i].be; adc_sat = VECS[i].sat;
            set_meas(VECS[i].s, VECS[i].b, VECS[i].c, VECS[i].l);
            strobe();
            check($sformatf("R5/R6/R7/R8 vec%0d coarse", i), 16'(gain_coarse), 16'(VECS[i].ec));
            check($sformatf("R4/R5/R8 vec%0d fine", i), 16'(gain_fine), 16'(VECS[i].ef));
            check($sformatf("R11 vec%0d rb", i), gain_rb, {VECS[i].ec, VECS[i].ef});
        end
        adc_sat = 0;

        // R7 delay of 2 quiet lines before increase
        inc_delay = 2; fe_refs = 4'b0001; be_refs = 0;
        set_meas(400, 500, 500, 500);
        strobe(); check("R7 line1", 16'(gain_coarse), 16'd5);
        strobe(); check("R7 line2", 16'(gain_coarse), 16'd5);
        strobe(); check("R7 line3", 16'(gain_coarse), 16'd6);
        inc_delay = 0;

        // R10 low clamp via clipping; R4 fine unchanged
        adc_sat = 1;
        for (int i = 0; i < 10; i++) strobe();
        check("R10 coarse floor", 16'(gain_coarse), 16'd0);
        check("R4 fine kept", 16'(gain_fine), 16'd2064);
        adc_sat = 0;

        // R10 high clamp coarse
        for (int i = 0; i < 20; i++) strobe();
        check("R10 coarse ceiling", 16'(gain_coarse), 16'd15);

        // R10 fine clamps
        fe_refs = 0; be_refs = 4'b0001; inc_step = 12'hFFF;
        strobe();
        check("R10 fine ceiling", 16'(gain_fine), 16'd4095);
        set_meas(600, 500, 500, 500);
        strobe();
        check("R10 fine floor", 16'(gain_fine), 16'd0);
        check("R8 coarse held", 16'(gain_coarse), 16'd15);

        // R2 manual
        auto_en = 0; man_coarse = 4'hA; man_fine = 12'h123;
        #1;
        check("R2 coarse", 16'(gain_coarse), 16'hA);
        check("R2 fine", 16'(gain_fine), 16'h123);
        check("R2 rb", gain_rb, 16'hA123);
        // R3 strobes ignored while manual
        fe_refs = 4'b0001; adc_sat = 1;
        strobe(); strobe(); strobe();
        check("R3 manual held", gain_rb, 16'hA123);
        adc_sat = 0; fe_refs = 0; be_refs = 0;
        auto_en = 1;
        #1;
        check("R3 resume", gain_rb, 16'hF000);

        // R9 no strobe, clipping and errors present
        @(negedge clk);
        fe_refs = 4'b0001; be_refs = 4'b0001; adc_sat = 1;
        set_meas(700, 500, 500, 500);
        repeat (5) @(negedge clk);
        check("R9 no strobe", gain_rb, 16'hF000);
        adc_sat = 0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule